// File: doc/BRIEF.md
# Binary Buddy Block Allocator

This block hands out and takes back blocks of a memory region whose size is a power of two. Every block it manages is a power of two in size, between a smallest and a largest order, and is aligned to its own size. The region itself is one block of the largest order. The allocator never touches the memory. It keeps only a free bitmap per order, with one bit per aligned block of that order, and works out placement from those bitmaps.

An allocate request carries a byte count. The block rounds the count up to an order and takes the lowest-addressed free block from the smallest order that can hold it. If that block is larger than needed, the block halves it once per cycle and returns each upper half to the free bitmap of its order. A free request carries a base address and an order. The block checks it, then joins it with its partner block one order at a time for as long as the partner is free. The partner address is the base with the order bit flipped. Requests enter through a valid/ready handshake. The block is busy while it works and gives a one-cycle response pulse when it finishes.

Top module: `buddy_alloc`

## Requirements
- R1: After synchronous reset the whole region is free as one block of the largest order (12) at address 0, `busy` is low, `req_ready` is high and `rsp_valid` is low.
- R2: An allocate of k bytes is served by a block of order max(4, ceil(log2 k)), and a size of 0 counts as order 4. `rsp_order` reports that order.
- R3: An allocate takes the lowest-addressed free block of the smallest order that is free and at least the requested order.
- R4: When only a larger block is free, it is halved until the requested order is reached. The lower half is kept each time and the upper half becomes free at its order, so later allocates find it.
- R5: A successful response has `rsp_addr` aligned to 2^`rsp_order`.
- R6: An allocate larger than 4096 bytes fails with `rsp_ok` low and leaves every free bitmap unchanged.
- R7: An allocate that finds no free block of an adequate order fails and leaves the bitmaps unchanged.
- R8: A valid free merges the block with its free partner (address with bit `order` flipped), repeating upward to order 12. `rsp_addr`/`rsp_order` give the base and order of the final merged free block.
- R9: A free fails without any state change if the order is outside 4..12, if the address has any bit below the order set, or if the block is already free or lies inside a larger free block.
- R10: `req_op` 0 is allocate and 1 is free. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `busy` (the inverse of `req_ready`) is high from the cycle after acceptance through the response cycle. Each accepted request gives exactly one single-cycle `rsp_valid`. A failed response shows address 0 and order 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 1 | 0 allocate, 1 free |
| req_size | input | 16 | Allocate byte count |
| req_addr | input | 12 | Free base address |
| req_order | input | 4 | Free block order |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | Request succeeded |
| rsp_addr | output | 12 | Allocated base, or merged free base |
| rsp_order | output | 4 | Allocated order, or merged free order |

## Verification
The bench drives one full split from order 12 down to order 4, then frees blocks in an order that forces a merge chain all the way back to a single region. A design that flipped the wrong address bit or stopped merging one level early would report a smaller final order. Requests of exactly 4096 and 4097 bytes, a full region, an already-freed block, a block inside a larger free block, a misaligned address and an order below the minimum each probe one failure path. Later allocations then show that no failure leaked a change into the bitmaps. Sizes one byte above a power of two, and a size of zero, catch rounding that is off by one order.

// File: rtl/buddy_pkg.sv
package buddy_pkg;

    localparam int BA_MIN_ORD = 4;
    localparam int BA_MAX_ORD = 12;
    localparam int BA_SIZE_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPLIT = 2'd1,
        ST_MERGE = 2'd2,
        ST_RESP  = 2'd3
    } ba_state_e;

    typedef enum logic {
        OP_ALLOC = 1'b0,
        OP_FREE  = 1'b1
    } ba_op_e;

    // smallest r with 2^r >= v (0 for v <= 1)
    function automatic int ceil_log2(input longint v);
        int r;
        r = 40;
        for (int i = 39; i >= 0; i--) begin
            if ((longint'(1) << i) >= v) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/buddy_size_class.sv
module buddy_size_class
    import buddy_pkg::*;
#(
    parameter int MIN_ORD = BA_MIN_ORD,
    parameter int MAX_ORD = BA_MAX_ORD,
    parameter int SIZE_W  = BA_SIZE_W,
    parameter int ORD_W   = $clog2(MAX_ORD + 1)
) (
    input  logic [SIZE_W-1:0] size,
    output logic [ORD_W-1:0]  ord,
    output logic              too_big
);
    int lg;

    always_comb begin
        lg      = ceil_log2(longint'(size));
        too_big = (lg > MAX_ORD);
        if (lg < MIN_ORD) lg = MIN_ORD;
        ord = too_big ? ORD_W'(MAX_ORD) : ORD_W'(lg);
    end
endmodule

// File: rtl/buddy_pick.sv
module buddy_pick #(
    parameter int NUM_ORD = 9,
    parameter int IDX_W   = 8,
    parameter int MAXBLK  = 1 << IDX_W,
    parameter int ORL_W   = $clog2(NUM_ORD)
) (
    input  logic [NUM_ORD-1:0][MAXBLK-1:0] free_map,
    input  logic [ORL_W-1:0]               min_rel,
    output logic                           found,
    output logic [ORL_W-1:0]               ord_rel,
    output logic [IDX_W-1:0]               idx
);
    logic [NUM_ORD-1:0]            any_free;
    logic [NUM_ORD-1:0][IDX_W-1:0] low_idx;

    for (genvar g = 0; g < NUM_ORD; g++) begin : g_ord
        logic [IDX_W-1:0] low_g;
        always_comb begin
            low_g = '0;
            for (int b = MAXBLK - 1; b >= 0; b--) begin
                if (free_map[g][b]) low_g = IDX_W'(b);
            end
        end
        assign any_free[g] = |free_map[g];
        assign low_idx[g]  = low_g;
    end

    // smallest adequate order wins; scanning downward lets it overwrite
    always_comb begin
        found   = 1'b0;
        ord_rel = '0;
        idx     = '0;
        for (int o = NUM_ORD - 1; o >= 0; o--) begin
            if (any_free[o] && (o >= int'(min_rel))) begin
                found   = 1'b1;
                ord_rel = ORL_W'(o);
                idx     = low_idx[o];
            end
        end
    end
endmodule

// File: rtl/buddy_free_check.sv
module buddy_free_check #(
    parameter int MIN_ORD = 4,
    parameter int MAX_ORD = 12,
    parameter int NUM_ORD = MAX_ORD - MIN_ORD + 1,
    parameter int IDX_W   = MAX_ORD - MIN_ORD,
    parameter int MAXBLK  = 1 << IDX_W,
    parameter int ADDR_W  = MAX_ORD,
    parameter int ORD_W   = $clog2(MAX_ORD + 1)
) (
    input  logic [NUM_ORD-1:0][MAXBLK-1:0] free_map,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [ORD_W-1:0]               ord,
    output logic                           ok
);
    always_comb begin
        ok = 1'b1;
        if ((int'(ord) < MIN_ORD) || (int'(ord) > MAX_ORD)) begin
            ok = 1'b0;
        end else begin
            for (int b = 0; b < ADDR_W; b++) begin
                if ((b < int'(ord)) && addr[b]) ok = 1'b0;
            end
            // the block itself or any enclosing block already free
            for (int o = MIN_ORD; o <= MAX_ORD; o++) begin
                if ((o >= int'(ord)) && free_map[o - MIN_ORD][IDX_W'(addr >> o)])
                    ok = 1'b0;
            end
        end
    end
endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc
    import buddy_pkg::*;
#(
    parameter int MIN_ORD = BA_MIN_ORD,
    parameter int MAX_ORD = BA_MAX_ORD,
    parameter int SIZE_W  = BA_SIZE_W,
    localparam int ADDR_W  = MAX_ORD,
    localparam int NUM_ORD = MAX_ORD - MIN_ORD + 1,
    localparam int IDX_W   = MAX_ORD - MIN_ORD,
    localparam int MAXBLK  = 1 << IDX_W,
    localparam int ORD_W   = $clog2(MAX_ORD + 1),
    localparam int ORL_W   = $clog2(NUM_ORD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ORD_W-1:0]  req_order,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [ORD_W-1:0]  rsp_order
);
    ba_state_e                      state_q;
    logic                           ok_q;
    logic [ORD_W-1:0]               cur_q, tgt_q;
    logic [ADDR_W-1:0]              addr_q;
    logic [NUM_ORD-1:0][MAXBLK-1:0] free_q;

    // request classification
    logic [ORD_W-1:0]  want_ord;
    logic              too_big;
    logic              pk_found;
    logic [ORL_W-1:0]  pk_rel;
    logic [IDX_W-1:0]  pk_idx;
    logic [ORD_W-1:0]  pk_ord;
    logic [ADDR_W-1:0] pk_addr;
    logic              fr_ok;

    buddy_size_class #(
        .MIN_ORD(MIN_ORD), .MAX_ORD(MAX_ORD), .SIZE_W(SIZE_W), .ORD_W(ORD_W)
    ) i_size (
        .size(req_size), .ord(want_ord), .too_big(too_big)
    );

    buddy_pick #(
        .NUM_ORD(NUM_ORD), .IDX_W(IDX_W), .MAXBLK(MAXBLK), .ORL_W(ORL_W)
    ) i_pick (
        .free_map(free_q),
        .min_rel (ORL_W'(want_ord - ORD_W'(MIN_ORD))),
        .found   (pk_found),
        .ord_rel (pk_rel),
        .idx     (pk_idx)
    );

    buddy_free_check #(
        .MIN_ORD(MIN_ORD), .MAX_ORD(MAX_ORD), .NUM_ORD(NUM_ORD), .IDX_W(IDX_W),
        .MAXBLK(MAXBLK), .ADDR_W(ADDR_W), .ORD_W(ORD_W)
    ) i_fchk (
        .free_map(free_q), .addr(req_addr), .ord(req_order), .ok(fr_ok)
    );

    assign pk_ord  = ORD_W'(pk_rel) + ORD_W'(MIN_ORD);
    assign pk_addr = ADDR_W'(pk_idx) << pk_ord;

    // walk-step helpers
    logic [ORL_W-1:0]  cur_rel;
    logic [ORD_W-1:0]  cur_dn;
    logic [ADDR_W-1:0] upper_half;
    logic [IDX_W-1:0]  own_idx, mate_idx, half_idx;

    assign cur_rel    = ORL_W'(cur_q - ORD_W'(MIN_ORD));
    assign cur_dn     = cur_q - ORD_W'(1);
    assign upper_half = addr_q | (ADDR_W'(1) << cur_dn);
    assign own_idx    = IDX_W'(addr_q >> cur_q);
    assign mate_idx   = own_idx ^ IDX_W'(1);
    assign half_idx   = IDX_W'(upper_half >> cur_dn);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ok_q    <= 1'b0;
            cur_q   <= '0;
            tgt_q   <= '0;
            addr_q  <= '0;
            free_q  <= '0;
            free_q[NUM_ORD-1][0] <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_op == OP_ALLOC) begin
                            if (too_big || !pk_found) begin
                                ok_q    <= 1'b0;
                                cur_q   <= '0;
                                addr_q  <= '0;
                                state_q <= ST_RESP;
                            end else begin
                                free_q[pk_rel][pk_idx] <= 1'b0;
                                ok_q    <= 1'b1;
                                cur_q   <= pk_ord;
                                tgt_q   <= want_ord;
                                addr_q  <= pk_addr;
                                state_q <= ST_SPLIT;
                            end
                        end else begin
                            if (!fr_ok) begin
                                ok_q    <= 1'b0;
                                cur_q   <= '0;
                                addr_q  <= '0;
                                state_q <= ST_RESP;
                            end else begin
                                ok_q    <= 1'b1;
                                cur_q   <= req_order;
                                addr_q  <= req_addr;
                                state_q <= ST_MERGE;
                            end
                        end
                    end
                end
                ST_SPLIT: begin
                    if (cur_q == tgt_q) begin
                        state_q <= ST_RESP;
                    end else begin
                        free_q[cur_rel - ORL_W'(1)][half_idx] <= 1'b1;
                        cur_q <= cur_dn;
                    end
                end
                ST_MERGE: begin
                    if ((int'(cur_q) < MAX_ORD) && free_q[cur_rel][mate_idx]) begin
                        free_q[cur_rel][mate_idx] <= 1'b0;
                        addr_q <= addr_q & ~(ADDR_W'(1) << cur_q);
                        cur_q  <= cur_q + ORD_W'(1);
                    end else begin
                        free_q[cur_rel][own_idx] <= 1'b1;
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign busy      = ~req_ready;
    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_ok    = ok_q;
    assign rsp_addr  = addr_q;
    assign rsp_order = cur_q;

    // R5: returned base is aligned to its order
    p_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ok) |-> ((rsp_addr & ~({ADDR_W{1'b1}} << rsp_order)) == '0));

    // R2: successful responses carry an order in the managed range
    p_order_range_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ok) |-> ((int'(rsp_order) >= MIN_ORD) && (int'(rsp_order) <= MAX_ORD)));

    // R6, R7, R9: a failed request leaves the bitmaps untouched
    p_fail_keeps_map_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok) |-> (free_q == $past(free_q)));

    // R4: splitting never goes below the requested order
    p_split_floor_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SPLIT) |-> (cur_q >= tgt_q));

    // R10: response is a single-cycle strobe
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R10: work only starts on a presented request
    p_busy_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/test_buddy_alloc.sv
module test_buddy_alloc;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_op;
    logic [15:0] req_size;
    logic [11:0] req_addr;
    logic [3:0]  req_order;
    logic        busy, rsp_valid, rsp_ok;
    logic [11:0] rsp_addr;
    logic [3:0]  rsp_order;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    buddy_alloc i_buddy_alloc (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_size(req_size), .req_addr(req_addr), .req_order(req_order),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_addr(rsp_addr), .rsp_order(rsp_order)
    );

    typedef struct packed {
        logic        op;
        logic [15:0] size;
        logic [11:0] addr;
        logic [3:0]  ord;
        logic        eok;
        logic [11:0] eaddr;
        logic [3:0]  eord;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd16,   12'd0,    4'd0,  1'b1, 12'd0,    4'd4,  8'd4}, // R4 R1 full split
        '{1'b0, 16'd17,   12'd0,    4'd0,  1'b1, 12'd32,   4'd5,  8'd2}, // R2 17 -> order 5
        '{1'b0, 16'd0,    12'd0,    4'd0,  1'b1, 12'd16,   4'd4,  8'd2}, // R2 zero -> order 4
        '{1'b0, 16'd100,  12'd0,    4'd0,  1'b1, 12'd128,  4'd7,  8'd3}, // R3 lowest order-7
        '{1'b0, 16'd4096, 12'd0,    4'd0,  1'b0, 12'd0,    4'd0,  8'd7}, // R7 no order-12
        '{1'b0, 16'd4097, 12'd0,    4'd0,  1'b0, 12'd0,    4'd0,  8'd6}, // R6 too big
        '{1'b1, 16'd0,    12'd16,   4'd4,  1'b1, 12'd16,   4'd4,  8'd8}, // R8 no merge
        '{1'b1, 16'd0,    12'd16,   4'd4,  1'b0, 12'd0,    4'd0,  8'd9}, // R9 double free
        '{1'b1, 16'd0,    12'd8,    4'd4,  1'b0, 12'd0,    4'd0,  8'd9}, // R9 misaligned
        '{1'b1, 16'd0,    12'd0,    4'd3,  1'b0, 12'd0,    4'd0,  8'd9}, // R9 order low
        '{1'b1, 16'd0,    12'd0,    4'd4,  1'b1, 12'd0,    4'd5,  8'd8}, // R8 one merge
        '{1'b1, 16'd0,    12'd32,   4'd5,  1'b1, 12'd0,    4'd7,  8'd8}, // R8 two merges
        '{1'b1, 16'd0,    12'd128,  4'd7,  1'b1, 12'd0,    4'd12, 8'd8}, // R8 to top
        '{1'b0, 16'd4096, 12'd0,    4'd0,  1'b1, 12'd0,    4'd12, 8'd2}, // R2 exact max
        '{1'b0, 16'd16,   12'd0,    4'd0,  1'b0, 12'd0,    4'd0,  8'd7}, // R7 full
        '{1'b1, 16'd0,    12'd0,    4'd12, 1'b1, 12'd0,    4'd12, 8'd8}, // R8 free whole
        '{1'b0, 16'd2048, 12'd0,    4'd0,  1'b1, 12'd0,    4'd11, 8'd3}, // R3
        '{1'b0, 16'd1025, 12'd0,    4'd0,  1'b1, 12'd2048, 4'd11, 8'd2}, // R2 round up
        '{1'b0, 16'd1,    12'd0,    4'd0,  1'b0, 12'd0,    4'd0,  8'd7}, // R7
        '{1'b1, 16'd0,    12'd2048, 4'd11, 1'b1, 12'd2048, 4'd11, 8'd8}, // R8 mate busy
        '{1'b0, 16'd300,  12'd0,    4'd0,  1'b1, 12'd2048, 4'd9,  8'd4}, // R4 split 11->9
        '{1'b0, 16'd600,  12'd0,    4'd0,  1'b1, 12'd3072, 4'd10, 8'd4}, // R4 upper half
        '{1'b0, 16'd512,  12'd0,    4'd0,  1'b1, 12'd2560, 4'd9,  8'd4}, // R4 upper half
        '{1'b1, 16'd0,    12'd0,    4'd11, 1'b1, 12'd0,    4'd11, 8'd8}, // R8
        '{1'b1, 16'd0,    12'd512,  4'd9,  1'b0, 12'd0,    4'd0,  8'd9}  // R9 inside free
    };

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_req(input logic op, input logic [15:0] size,
                          input logic [11:0] addr, input logic [3:0] ord,
                          output logic ok, output logic [11:0] raddr,
                          output logic [3:0] rord);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_size = size;
        req_addr = addr; req_order = ord;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1 && req_ready == 1'b0, "R10", "busy after accept", busy, 1);
        while (!rsp_valid) @(negedge clk);
        ok = rsp_ok; raddr = rsp_addr; rord = rsp_order;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10", "strobe width", rsp_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog actual=hung expected=response");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic        ok;
        logic [11:0] ra;
        logic [3:0]  ro;
        rst = 1'b1; req_valid = 1'b0; req_op = 1'b0;
        req_size = '0; req_addr = '0; req_order = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);

        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].op, VECS[i].size, VECS[i].addr, VECS[i].ord, ok, ra, ro);
            chk(ok == VECS[i].eok, $sformatf("R%0d", VECS[i].req),
                $sformatf("vec%0d ok", i), ok, VECS[i].eok);
            if (VECS[i].eok) begin
                chk(ra == VECS[i].eaddr, $sformatf("R%0d", VECS[i].req),
                    $sformatf("vec%0d addr", i), ra, VECS[i].eaddr);
                chk(ro == VECS[i].eord, $sformatf("R%0d", VECS[i].req),
                    $sformatf("vec%0d order", i), ro, VECS[i].eord);
            end else begin
                // R10 failed response shows zero address and order
                chk(ra == 12'd0 && ro == 4'd0, "R10", $sformatf("vec%0d fail fields", i),
                    {ra, ro}, 0);
            end
        end

        // R4 R5: deep split from order 11 down to 4 lands at base 0
        do_req(1'b0, 16'd9, 12'd0, 4'd0, ok, ra, ro);
        chk(ok && ra == 12'd0 && ro == 4'd4, "R4", "deep split", {ok, ra, ro}, {1'b1, 12'd0, 4'd4});
        // R3: its upper buddy at order 4 is next
        do_req(1'b0, 16'd16, 12'd0, 4'd0, ok, ra, ro);
        chk(ok && ra == 12'd16 && ro == 4'd4, "R3", "lowest order-4", {ok, ra, ro}, {1'b1, 12'd16, 4'd4});
        // R5: an order-8 allocate comes from the split remainders, aligned
        do_req(1'b0, 16'd200, 12'd0, 4'd0, ok, ra, ro);
        chk(ok && ra == 12'd256 && ro == 4'd8, "R5", "order-8 aligned", {ok, ra, ro}, {1'b1, 12'd256, 4'd8});
        // R9: order above range rejected
        do_req(1'b1, 16'd0, 12'd0, 4'd13, ok, ra, ro);
        chk(ok == 1'b0, "R9", "order high", ok, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule